// File: doc/BRIEF.md
# Privilege-Gated Timer Clock Prescaler

This block is a small timer register bank with a clock-rate divider. Software reaches it over a simple register bus. Every access carries a flag that says whether it was issued in user mode or in privileged mode.

A mode register holds three fields:
- a timer-enable bit;
- a write-protection bit;
- a two-bit rate-select field.

The rate-select field sets how often the prescaler raises its one-cycle timer tick. The choices are every bus clock, every fourth, every eighth or every sixteenth.

While the protection bit is set, user-mode writes to the timer registers are dropped without any error indication. The same applies to the two watchdog registers. Privileged writes are always accepted. Reads are served in both modes.

A down counter consumes the tick, so software can see the divided rate through the count register.

The prescaler is a two-state machine:
- `PS_BYPASS`: the tick is high on every cycle. This state is used for select 00.
- `PS_DIVIDE`: the tick fires when the masked phase counter is zero. This state is used for selects 01, 10 and 11.

The machine follows the next value of the select field. It takes the transition `to_divide` when that value becomes non-zero and `to_bypass` when it becomes zero. Any change of the select field takes the restart transition, which reloads the phase counter to 1. A hardware reset or a one-cycle synchronous software-reset pulse clears the mode register, which returns the tick to full rate.

Top module: `tmr_prescale_top`

## Requirements
- R1: After hardware reset the mode register (address 0) reads 0 and `tmr_tick` is high on every cycle.
- R2: The mode register layout is: bit 0 timer enable, bit 3 write protection, bits 5:4 rate select. All other bits read as 0.
- R3: Rate select 00, 01, 10 and 11 give a tick period of 1, 4, 8 and 16 bus cycles respectively.
- R4: When an accepted write or a software reset changes the rate select, the next tick is high in the cycle that follows the N-th rising edge, where N is the new ratio. The edge that stores the change counts as the first.
- R5: After that first tick, ticks repeat every N cycles and are low in between.
- R6: With the protection bit at 1, user-mode writes to the mode (0), count (1) and reload (2) registers leave them unchanged. This includes the rate select and its tick phase.
- R7: Privileged-mode writes update the registers whatever the value of the protection bit.
- R8: With the protection bit at 0, user-mode writes update the timer registers.
- R9: Reads return the stored value in both user and privileged mode.
- R10: The watchdog control (3) and watchdog setup (4) registers follow the same user/privileged write rule under the same protection bit.
- R11: A one-cycle `sw_rst` pulse clears the whole mode register, including the protection bit and the rate select.
- R12: While enabled, the count (1) decrements on each tick and reloads from the reload register on the tick after it reaches 0. A counter that has just been enabled starts on the edge after the one that set the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous one-cycle software reset |
| bus_wr | input | 1 | Write strobe |
| bus_priv | input | 1 | 1 = privileged access, 0 = user access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| tmr_tick | output | 1 | One-cycle timer clock enable |

## Verification
The bench times the first tick after every select change. A prescaler that kept its old phase, or was reloaded with 0, would tick too early or at once.

It attempts user-mode writes while protection is set, including one that tries to clear the protection bit itself and one to the watchdog registers. A gate that looked only at the address, or ignored the mode flag, would let these through.

Software reset is applied while the divided rate is active. A reset that left the select field intact would leave the tick divided.

The counter is sampled through its reload at zero, which exposes an off-by-one in either the decrement or the reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 4;

    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] A_RELD  = 3'd2;
    localparam logic [ADDR_W-1:0] A_WDCTL = 3'd3;
    localparam logic [ADDR_W-1:0] A_WDSET = 3'd4;

    localparam int EN_BIT  = 0;
    localparam int PRI_BIT = 3;
    localparam int SEL_LO  = 4;

    typedef enum logic [1:0] {
        SEL_DIV1  = 2'b00,
        SEL_DIV4  = 2'b01,
        SEL_DIV8  = 2'b10,
        SEL_DIV16 = 2'b11
    } sel_e;

    typedef enum logic {
        PS_BYPASS = 1'b0,
        PS_DIVIDE = 1'b1
    } ps_state_e;

    function automatic logic [PRE_W-1:0] sel_mask(sel_e s);
        case (s)
            SEL_DIV4:  sel_mask = PRE_W'(3);
            SEL_DIV8:  sel_mask = PRE_W'(7);
            SEL_DIV16: sel_mask = PRE_W'(15);
            default:   sel_mask = '0;
        endcase
    endfunction
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst_i,
    input  logic              bus_wr_i,
    input  logic              bus_priv_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [DATA_W-1:0] cnt_val_i,
    output logic              cnt_ld_o,
    output logic              en_o,
    output sel_e              sel_q_o,
    output sel_e              sel_d_o,
    output logic [DATA_W-1:0] reload_o
);
    logic              en_q, en_d, pri_q, pri_d;
    sel_e              sel_q, sel_d;
    logic [DATA_W-1:0] reload_q, wdctl_q, wdset_q;
    logic              wr_ok;
    logic [DATA_W-1:0] mode_rd;

    // Write gate: user accesses are dropped while protection is set.
    assign wr_ok = bus_wr_i && (bus_priv_i || !pri_q);

    always_comb begin
        en_d  = en_q;
        pri_d = pri_q;
        sel_d = sel_q;
        if (sw_rst_i) begin
            en_d  = 1'b0;
            pri_d = 1'b0;
            sel_d = SEL_DIV1;
        end else if (wr_ok && bus_addr_i == A_MODE) begin
            en_d  = bus_wdata_i[EN_BIT];
            pri_d = bus_wdata_i[PRI_BIT];
            sel_d = sel_e'(bus_wdata_i[SEL_LO+1:SEL_LO]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            pri_q    <= 1'b0;
            sel_q    <= SEL_DIV1;
            reload_q <= '0;
            wdctl_q  <= '0;
            wdset_q  <= '0;
        end else begin
            en_q  <= en_d;
            pri_q <= pri_d;
            sel_q <= sel_d;
            if (wr_ok && bus_addr_i == A_RELD)  reload_q <= bus_wdata_i;
            if (wr_ok && bus_addr_i == A_WDCTL) wdctl_q  <= bus_wdata_i;
            if (wr_ok && bus_addr_i == A_WDSET) wdset_q  <= bus_wdata_i;
        end
    end

    always_comb begin
        mode_rd                      = '0;
        mode_rd[EN_BIT]              = en_q;
        mode_rd[PRI_BIT]             = pri_q;
        mode_rd[SEL_LO+1:SEL_LO]     = sel_q;
        case (bus_addr_i)
            A_MODE:  bus_rdata_o = mode_rd;
            A_COUNT: bus_rdata_o = cnt_val_i;
            A_RELD:  bus_rdata_o = reload_q;
            A_WDCTL: bus_rdata_o = wdctl_q;
            A_WDSET: bus_rdata_o = wdset_q;
            default: bus_rdata_o = '0;
        endcase
    end

    assign cnt_ld_o = wr_ok && bus_addr_i == A_COUNT;
    assign en_o     = en_q;
    assign sel_q_o  = sel_q;
    assign sel_d_o  = sel_d;
    assign reload_o = reload_q;

    // R6: a user write under protection leaves the reload register alone
    p_user_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !bus_priv_i && pri_q && bus_addr_i == A_RELD) |=> $stable(reload_q));
    // R7: a privileged write always lands
    p_priv_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_priv_i && bus_addr_i == A_RELD) |=> reload_q == $past(bus_wdata_i));
    // R10: watchdog control obeys the same protection bit
    p_wd_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !bus_priv_i && pri_q && bus_addr_i == A_WDCTL) |=> $stable(wdctl_q));
    // R11: software reset clears protection and rate select
    p_swrst_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_i |=> (!pri_q && sel_q == SEL_DIV1 && !en_q));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sel_e sel_q_i,
    input  sel_e sel_d_i,
    output logic tick_o
);
    ps_state_e         state_q, state_d;
    logic [PRE_W-1:0]  phase_q;
    logic              restart;

    assign restart = (sel_d_i != sel_q_i);

    // Next state tracks the select value the register is about to hold.
    always_comb begin
        unique case (sel_d_i)
            SEL_DIV1: state_d = PS_BYPASS;
            default:  state_d = PS_DIVIDE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_BYPASS;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= restart ? PRE_W'(1) : phase_q + PRE_W'(1);
        end
    end

    always_comb begin
        unique case (state_q)
            PS_BYPASS: tick_o = 1'b1;
            PS_DIVIDE: tick_o = ((phase_q & sel_mask(sel_q_i)) == '0);
            default:   tick_o = 1'b1;
        endcase
    end

    // R4: a restart into a divided rate never ticks on the next cycle
    p_restart_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && sel_d_i != SEL_DIV1) |=> !tick_o);
    // R5: in divided mode two ticks are never adjacent
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DIVIDE && tick_o && !restart) |=> !tick_o);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] reload_i,
    output logic [DATA_W-1:0] cnt_o
);
    logic [DATA_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (ld_i)             cnt_q <= ld_data_i;
        else if (en_i && tick_i)   cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - DATA_W'(1);
    end

    assign cnt_o = cnt_q;

    // R12: an enabled tick steps a non-zero count down by one
    p_count_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && !ld_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DATA_W'(1));
endmodule

// File: rtl/tmr_prescale_top.sv
module tmr_prescale_top
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              bus_wr,
    input  logic              bus_priv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tmr_tick
);
    logic              cnt_ld, en;
    sel_e              sel_q, sel_d;
    logic [DATA_W-1:0] reload, cnt_val;

    tmr_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_rst_i    (sw_rst),
        .bus_wr_i    (bus_wr),
        .bus_priv_i  (bus_priv),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .cnt_val_i   (cnt_val),
        .cnt_ld_o    (cnt_ld),
        .en_o        (en),
        .sel_q_o     (sel_q),
        .sel_d_o     (sel_d),
        .reload_o    (reload)
    );

    tmr_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_q_i (sel_q),
        .sel_d_i (sel_d),
        .tick_o  (tmr_tick)
    );

    tmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (cnt_ld),
        .ld_data_i (bus_wdata),
        .en_i      (en),
        .tick_i    (tmr_tick),
        .reload_i  (reload),
        .cnt_o     (cnt_val)
    );
endmodule

// File: tb/tb_tmr_prescale_top.sv
module tb_tmr_prescale_top;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_rst = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_priv = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              tmr_tick;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tmr_prescale_top #(.DATA_W(DATA_W)) dut (
        .clk, .rst_n, .sw_rst, .bus_wr, .bus_priv,
        .bus_addr, .bus_wdata, .bus_rdata, .tmr_tick
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the storing edge.
    task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d, input logic priv);
        bus_addr = a; bus_wdata = d; bus_priv = priv; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic priv,
                          input logic [DATA_W-1:0] exp);
        bus_addr = a; bus_priv = priv;
        #1;
        chk(tag, bus_rdata, exp);
        bus_priv = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 mode after reset", 3'd0, 1'b1, 16'h0000);
        for (int k = 0; k < 4; k++) begin
            chk("R1 full-rate tick", tmr_tick, 1'b1);
            @(negedge clk);
        end
    endtask

    task automatic t_layout();
        wr(3'd0, 16'hFFFF, 1'b1);
        rd_chk("R2 mode layout", 3'd0, 1'b1, 16'h0039);
        wr(3'd0, 16'h0000, 1'b1);
        rd_chk("R2 mode cleared", 3'd0, 1'b1, 16'h0000);
    endtask

    // R3 R4 R5: timing of ticks after a select change
    task automatic t_rate(input logic [1:0] sel, input int ratio);
        wr(3'd0, DATA_W'(sel) << 4, 1'b1);
        for (int k = 1; k <= 34; k++) begin
            if (k <= ratio) chk("R4 first tick after select change", tmr_tick, (k % ratio) == 0);
            else            chk("R3 R5 tick period", tmr_tick, (k % ratio) == 0);
            @(negedge clk);
        end
    endtask

    task automatic t_protect();
        wr(3'd2, 16'h1234, 1'b1);
        wr(3'd0, 16'h0008, 1'b1);
        wr(3'd2, 16'h0055, 1'b0);
        rd_chk("R6 reload kept", 3'd2, 1'b1, 16'h1234);
        wr(3'd0, 16'h0030, 1'b0);
        rd_chk("R6 mode kept", 3'd0, 1'b1, 16'h0008);
        chk("R6 tick still full rate", tmr_tick, 1'b1);
        wr(3'd1, 16'h0077, 1'b0);
        rd_chk("R6 count kept", 3'd1, 1'b1, 16'h0000);
        wr(3'd2, 16'hABCD, 1'b1);
        rd_chk("R7 privileged write", 3'd2, 1'b0, 16'hABCD);
        rd_chk("R9 read in user mode", 3'd0, 1'b0, 16'h0008);
        rd_chk("R9 read in privileged mode", 3'd0, 1'b1, 16'h0008);
    endtask

    task automatic t_watchdog();
        wr(3'd3, 16'h00C3, 1'b0);
        rd_chk("R10 wd ctrl user write dropped", 3'd3, 1'b0, 16'h0000);
        wr(3'd3, 16'h00C3, 1'b1);
        rd_chk("R10 wd ctrl privileged write", 3'd3, 1'b0, 16'h00C3);
        wr(3'd0, 16'h0000, 1'b1);
        wr(3'd4, 16'h5A5A, 1'b0);
        rd_chk("R10 wd setup user write open", 3'd4, 1'b0, 16'h5A5A);
        wr(3'd2, 16'h0042, 1'b0);
        rd_chk("R8 reload user write open", 3'd2, 1'b1, 16'h0042);
    endtask

    task automatic t_swrst();
        wr(3'd0, 16'h0038, 1'b1);
        sw_rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sw_rst = 1'b0;
        rd_chk("R11 mode cleared by sw reset", 3'd0, 1'b1, 16'h0000);
        for (int k = 0; k < 3; k++) begin
            chk("R11 tick back to full rate", tmr_tick, 1'b1);
            @(negedge clk);
        end
    endtask

    task automatic t_counter();
        logic [DATA_W-1:0] exp_seq [6];
        exp_seq = '{16'd2, 16'd1, 16'd0, 16'd3, 16'd2, 16'd1};
        wr(3'd2, 16'd3, 1'b1);
        wr(3'd1, 16'd2, 1'b1);
        wr(3'd0, 16'h0001, 1'b1);
        bus_addr = 3'd1;
        for (int k = 0; k < 6; k++) begin
            #1;
            chk("R12 count sequence", bus_rdata, exp_seq[k]);
            @(negedge clk);
        end
        wr(3'd0, 16'h0000, 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_rate(2'b01, 4);
        t_rate(2'b10, 8);
        t_rate(2'b11, 16);
        t_rate(2'b00, 1);
        t_protect();
        t_watchdog();
        t_swrst();
        t_counter();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule